// File: doc/BRIEF.md
# Control-Register Triggered Software Trace Generator

This block sits beside the writeback and control-register write paths of a RISC-style core. Software emits a trace event by writing a 16-bit identifier to one non-standard control register. The block snoops every register-file writeback. It keeps the most recent data written to the first argument register (x10) and sends that data as the event value. It can also watch the thread-pointer register (x4) and produce a thread-switch event whenever that register is written. These events let a debugger follow context changes.

The output is a one-cycle event port: a 16-bit identifier, a value as wide as the general purpose registers, and an enable. The port has no backpressure, so the core is never stalled by tracing. All outputs are registered. An event appears on the cycle after the write that causes it. When a trace write and a thread-pointer write occur together, the trace event goes out first. The thread-switch event is held in a single pending slot and sent afterwards.

Top module: `swtrace_csr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `trc_en`, `trc_id` and `trc_value` are all zero.
- R2: A cycle with `csr_we` high, `csr_addr` equal to `TRACE_CSR` (default 0x8C0) and a nonzero value in `csr_wdata[15:0]` is a trace write. On the next cycle `trc_en` is high for exactly one cycle, and `trc_id` equals those 16 bits.
- R3: A control-register write to any other address, or a cycle with `csr_we` low, emits no event.
- R4: A write to `TRACE_CSR` with `csr_wdata[15:0]` equal to zero emits no event.
- R5: The value sent with a trace event is the data of the latest writeback with `wb_valid` high and `wb_idx` equal to 10. If that writeback happens in the same cycle as the trace write, its new data is sent.
- R6: A writeback to any index other than 10 leaves the stored trace value unchanged.
- R7: With `TRACK_TP` set, a writeback to index 4 emits an event on the next cycle. That event has `trc_id` equal to `THREAD_ID` (default 0xFFFF) and `trc_value` equal to the data written.
- R8: When a trace write and an index-4 writeback occur in the same cycle, the trace event is sent on the next cycle. The thread-switch event is sent on the cycle after that.
- R9: A held thread-switch event waits while further trace writes keep arriving. A newer index-4 writeback replaces a held one that has not yet been sent. Events go out in the order trace write, held thread switch, fresh thread switch.
- R10: Writeback data with `wb_valid` low changes neither the stored value nor the events.
- R11: Whenever `trc_en` is low, `trc_id` and `trc_value` are zero.
- R12: With `TRACK_TP` cleared, index-4 writebacks emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Control-register write strobe |
| csr_addr | input | CSR_ADDR_W | Control-register write address |
| csr_wdata | input | XLEN | Control-register write data |
| wb_valid | input | 1 | Register writeback valid |
| wb_idx | input | REG_IDX_W | Register writeback index |
| wb_data | input | XLEN | Register writeback data |
| trc_id | output | 16 | Event identifier |
| trc_value | output | XLEN | Event value |
| trc_en | output | 1 | Event valid for this cycle |

## Verification
The assertions assume that inputs are zero during reset and settle before each rising edge. They check the port only a cycle or two after a write. They therefore rely on no event arriving from the pending slot in between, unless the antecedent excludes that case. The stimulus drives every input on the falling edge and holds all strobes low through reset. It mixes directed sequences with random traffic that favours indices 4 and 10 and the trace address. This makes simultaneous and back-to-back writes frequent.

// File: rtl/swtrace_csr_gen.sv
module swtrace_csr_gen #(
  parameter int unsigned XLEN       = 32,
  parameter int unsigned REG_IDX_W  = 5,
  parameter int unsigned A0_IDX     = 10,
  parameter int unsigned TP_IDX     = 4,
  parameter int unsigned CSR_ADDR_W = 12,
  parameter logic [11:0] TRACE_CSR  = 12'h8C0,
  parameter bit          TRACK_TP   = 1'b1,
  parameter logic [15:0] THREAD_ID  = 16'hFFFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  csr_we,
  input  logic [CSR_ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]       csr_wdata,
  input  logic                  wb_valid,
  input  logic [REG_IDX_W-1:0]  wb_idx,
  input  logic [XLEN-1:0]       wb_data,
  output logic [15:0]           trc_id,
  output logic [XLEN-1:0]       trc_value,
  output logic                  trc_en
);

  localparam int unsigned ID_W = 16;

  logic [XLEN-1:0] val_q, pend_val_q, out_val_q;
  logic [ID_W-1:0] out_id_q;
  logic            out_en_q, pend_q;
  logic            fire, a0_hit, tp_hit;

  assign fire   = csr_we && (csr_addr == CSR_ADDR_W'(TRACE_CSR)) && (csr_wdata[ID_W-1:0] != '0);
  assign a0_hit = wb_valid && (wb_idx == REG_IDX_W'(A0_IDX));

  generate
    if (TRACK_TP) begin : g_tp
      assign tp_hit = wb_valid && (wb_idx == REG_IDX_W'(TP_IDX));
    end else begin : g_no_tp
      assign tp_hit = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_q      <= '0;
      pend_q     <= 1'b0;
      pend_val_q <= '0;
      out_en_q   <= 1'b0;
      out_id_q   <= '0;
      out_val_q  <= '0;
    end else begin
      if (a0_hit) val_q <= wb_data;
      out_en_q  <= 1'b0;
      out_id_q  <= '0;
      out_val_q <= '0;
      if (fire) begin
        out_en_q  <= 1'b1;
        out_id_q  <= csr_wdata[ID_W-1:0];
        out_val_q <= a0_hit ? wb_data : val_q;
        if (tp_hit) begin
          pend_q     <= 1'b1;
          pend_val_q <= wb_data;
        end
      end else if (pend_q) begin
        out_en_q  <= 1'b1;
        out_id_q  <= THREAD_ID;
        out_val_q <= pend_val_q;
        pend_q    <= tp_hit;
        if (tp_hit) pend_val_q <= wb_data;
      end else if (tp_hit) begin
        out_en_q  <= 1'b1;
        out_id_q  <= THREAD_ID;
        out_val_q <= wb_data;
      end
    end
  end

  assign trc_en    = out_en_q;
  assign trc_id    = out_id_q;
  assign trc_value = out_val_q;

  assert_trace_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> trc_en && trc_id == $past(csr_wdata[ID_W-1:0]));

  assert_silent_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_wdata[ID_W-1:0] == '0 && !pend_q && !tp_hit) |=> !trc_en);

  assert_fresh_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && a0_hit) |=> trc_value == $past(wb_data));

  assert_thread_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_hit && !fire && !pend_q) |=> trc_en && trc_id == THREAD_ID && trc_value == $past(wb_data));

  assert_thread_after_trace_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fire, 2) && $past(tp_hit, 2) && !$past(fire)) |->
      trc_en && trc_id == THREAD_ID && trc_value == $past(wb_data, 2));

  assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !trc_en |-> (trc_id == '0 && trc_value == '0));

  assert_no_thread_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!TRACK_TP && !fire) |=> !trc_en);

endmodule

// File: tb/swtrace_csr_gen_test.sv
`timescale 1ns/1ps
module swtrace_csr_gen_test;
  localparam int XLEN = 32;
  localparam logic [11:0] CSR = 12'h8C0;
  localparam logic [15:0] TID = 16'hFFFF;

  logic clk = 0, rst_n = 0;
  logic csr_we = 0; logic [11:0] csr_addr = '0; logic [XLEN-1:0] csr_wdata = '0;
  logic wb_valid = 0; logic [4:0] wb_idx = '0; logic [XLEN-1:0] wb_data = '0;
  logic [15:0] id_a, id_b; logic [XLEN-1:0] val_a, val_b; logic en_a, en_b;

  int checks = 0, errors = 0;
  logic [XLEN-1:0] m_val = '0;
  logic [XLEN-1:0] pq[$];

  always #5 clk = ~clk;

  swtrace_csr_gen uut (.clk, .rst_n, .csr_we, .csr_addr, .csr_wdata, .wb_valid, .wb_idx,
    .wb_data, .trc_id(id_a), .trc_value(val_a), .trc_en(en_a));
  swtrace_csr_gen #(.TRACK_TP(1'b0)) uut_notp (.clk, .rst_n, .csr_we, .csr_addr, .csr_wdata,
    .wb_valid, .wb_idx, .wb_data, .trc_id(id_b), .trc_value(val_b), .trc_en(en_b));

  task automatic check(string tag, logic en, logic [15:0] id, logic [XLEN-1:0] v,
                       logic een, logic [15:0] eid, logic [XLEN-1:0] ev);
    checks++;
    if (en !== een || id !== eid || v !== ev) begin
      errors++;
      $display("FAIL %s: actual en=%0b id=%h val=%h expected en=%0b id=%h val=%h",
               tag, en, id, v, een, eid, ev);
    end
  endtask

  task automatic cyc(string tag);
    logic fire, a0, tp, een, e2;
    logic [15:0] eid, eid2; logic [XLEN-1:0] ev, ev2, nv;
    fire = csr_we && csr_addr == CSR && csr_wdata[15:0] != 0;
    a0 = wb_valid && wb_idx == 10;
    tp = wb_valid && wb_idx == 4;
    nv = a0 ? wb_data : m_val;
    een = 0; eid = 0; ev = 0;
    if (fire) begin
      een = 1; eid = csr_wdata[15:0]; ev = nv;
      if (tp) begin pq.delete(); pq.push_back(wb_data); end
    end else if (pq.size() > 0) begin
      een = 1; eid = TID; ev = pq.pop_front();
      if (tp) pq.push_back(wb_data);
    end else if (tp) begin
      een = 1; eid = TID; ev = wb_data;
    end
    e2 = fire; eid2 = fire ? csr_wdata[15:0] : 16'h0; ev2 = fire ? nv : '0;
    m_val = nv;
    @(posedge clk); #2;
    check(tag, en_a, id_a, val_a, een, eid, ev);
    check({tag, " R12"}, en_b, id_b, val_b, e2, eid2, ev2);
    @(negedge clk);
    csr_we = 0; wb_valid = 0;
  endtask

  task automatic csrw(logic [11:0] a, logic [XLEN-1:0] d);
    csr_we = 1; csr_addr = a; csr_wdata = d;
  endtask
  task automatic wbw(logic [4:0] i, logic [XLEN-1:0] d);
    wb_valid = 1; wb_idx = i; wb_data = d;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL R1 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", en_a, id_a, val_a, 0, 0, 0);
    rst_n = 1;
    cyc("R1 first");
    wbw(10, 32'h1111_2222); cyc("R5 capture");
    csrw(CSR, 32'hABCD_0042); cyc("R2 emit");
    cyc("R2 single pulse");
    csrw(12'h8C1, 32'h0000_0033); cyc("R3 other addr");
    csr_addr = CSR; csr_wdata = 32'h55; cyc("R3 we low");
    csrw(CSR, 32'hFFFF_0000); cyc("R4 zero id");
    wbw(11, 32'hDEAD_BEEF); cyc("R6 other reg");
    csrw(CSR, 32'h0000_0007); cyc("R6 value kept");
    wb_idx = 10; wb_data = 32'h0BAD_0BAD; cyc("R10 invalid wb");
    csrw(CSR, 32'h0000_0008); cyc("R10 value kept");
    wbw(10, 32'h7777_8888); csrw(CSR, 32'h0000_0009); cyc("R5 same cycle");
    wbw(4, 32'h0000_4444); cyc("R7 thread");
    csrw(CSR, 32'h0000_000A); wbw(4, 32'h0000_5555); cyc("R8 trace first");
    cyc("R8 thread follows");
    cyc("R8 idle");
    csrw(CSR, 32'h0000_000B); wbw(4, 32'h0000_6666); cyc("R9 trace");
    csrw(CSR, 32'h0000_000C); wbw(4, 32'h0000_7777); cyc("R9 trace again");
    csrw(CSR, 32'h0000_000D); cyc("R9 held waits");
    wbw(4, 32'h0000_8888); cyc("R9 held then fresh");
    cyc("R9 fresh");
    cyc("R11 idle");
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(0, 2) != 0)
        csrw(($urandom_range(0, 3) != 0) ? CSR : 12'h8C2,
             ($urandom_range(0, 4) == 0) ? 32'h0 : $urandom());
      if ($urandom_range(0, 2) != 0)
        wbw(($urandom_range(0, 3) == 0) ? 5'($urandom_range(0, 31)) :
            (($urandom_range(0, 1) != 0) ? 5'd4 : 5'd10), $urandom());
      cyc("R2 R5 R7 R9 random");
    end
    repeat (3) cyc("R11 drain");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule